// File: doc/BRIEF.md
# Stereo Automatic Gain-Limiting Controller

This block watches a stream of signed stereo sample pairs coming out of a converter and steers the gain of two front-end amplifiers. It holds one shared attenuation offset, counted in 0.5 dB steps. Each amplifier gets its own initial gain code minus that offset, so the dB difference between the channels stays the same while the overall level is pulled down. A loud input raises the offset step by step until the level falls below a limit. The gain can then be restored under one of three policies: never restore, restore freely, or restore until a set number of recovery intervals have seen the signal above a lower threshold.

All settings, including the two initial gain codes, are sampled while the block is disabled and held while it is enabled. A one-cycle restart pulse, or dropping enable, clears the offset and all internal timing. Both the attack interval and the recovery interval are counted in valid samples.

Top module: `stereo_gain_limiter`

## Requirements
- R1: A valid sample pair is "over attack" when the two's-complement magnitude of a channel is strictly greater than the attack threshold (-32768 has magnitude 32768). Outside attack, an over-attack pair adds one step to the offset and raises `attacking` in the cycle after the sample.
- R2: With attack interval code K, the K valid samples after a step are not evaluated. The next sample then adds another step if it is over attack; otherwise `attacking` falls and the offset is kept.
- R3: `gain_l` and `gain_r` equal their latched initial code minus the offset, with a floor of 0. They never exceed the initial code, and both channels lose the same number of steps.
- R4: With `both_mode` = 1, a level event (attack or recovery) needs both channels over the threshold. With `both_mode` = 0, either channel over the threshold is enough.
- R5: Settings and initial gains are copied from the inputs each cycle while `en` = 0 and are held while `en` = 1. A change made while enabled has no effect until the block is disabled and enabled again.
- R6: Recovery mode code 0 (none) never lowers the offset until a restart. Code 3 behaves the same way.
- R7: Recovery mode code 1 (normal). Outside attack, recovery intervals of M+1 valid samples run, where M is the recovery interval code; they start when attack ends. At the last sample of an interval the offset drops by one, unless it is 0 already.
- R8: In normal mode the offset is held at the end of an interval in which any sample pair exceeded the recovery threshold (strictly greater, using the R4 rule).
- R9: Recovery mode code 2 (limited). An interval with an excursion above the recovery threshold increments a counter instead of recovering. When the count reaches the limit code L (L=0 acts as 1), `frozen` rises and recovery stops. A new attack clears the counter and `frozen`.
- R10: The offset saturates at 127 steps.
- R11: The restart pulse, or `en` = 0, clears the offset, timers, counter, `attacking` and `frozen` in one cycle. After reset, the gains equal the initial codes and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; settings are captured while low |
| restart | input | 1 | One-cycle pulse that clears the offset and timing |
| s_valid | input | 1 | Sample pair strobe |
| s_left | input | SW | Left sample, two's complement |
| s_right | input | SW | Right sample, two's complement |
| init_gain_l | input | GW | Left initial (maximum) gain code |
| init_gain_r | input | GW | Right initial (maximum) gain code |
| atk_thr | input | SW | Attack threshold (magnitude) |
| rec_thr | input | SW | Recovery threshold (magnitude) |
| atk_ivl | input | TW | Attack interval code K |
| rec_ivl | input | TW | Recovery interval code M |
| both_mode | input | 1 | 1: both channels must exceed the threshold |
| rec_mode | input | 2 | 0 none, 1 normal, 2 limited, 3 none |
| cnt_limit | input | CW | Limited-recovery count limit |
| gain_l | output | GW | Left amplifier gain code |
| gain_r | output | GW | Right amplifier gain code |
| attacking | output | 1 | Attack in progress |
| frozen | output | 1 | Limited recovery has stopped |

## Verification
A sweep over bursts of 1 to 12 loud pairs of alternating sign checks the offset against ceil(n/(K+1)), which tells the evaluated samples apart from the skipped ones. Samples exactly at a threshold and one count above it separate the strict comparison from an inclusive one. One-sided and two-sided loud pairs separate the two detection modes. Recovery runs with quiet intervals, intervals containing a mid-level excursion, and repeated excursions; these tell normal restoration, hold and the limited freeze apart. A long burst of full-scale negative samples checks the floor, saturation and magnitude of the most negative code.

// File: rtl/stereo_gain_limiter.sv
module stereo_gain_limiter #(
  parameter int SW = 16,
  parameter int GW = 7,
  parameter int OW = 7,
  parameter int TW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  input  logic          s_valid,
  input  logic [SW-1:0] s_left,
  input  logic [SW-1:0] s_right,
  input  logic [GW-1:0] init_gain_l,
  input  logic [GW-1:0] init_gain_r,
  input  logic [SW-1:0] atk_thr,
  input  logic [SW-1:0] rec_thr,
  input  logic [TW-1:0] atk_ivl,
  input  logic [TW-1:0] rec_ivl,
  input  logic          both_mode,
  input  logic [1:0]    rec_mode,
  input  logic [CW-1:0] cnt_limit,
  output logic [GW-1:0] gain_l,
  output logic [GW-1:0] gain_r,
  output logic          attacking,
  output logic          frozen
);
  localparam logic [OW-1:0] OFF_MAX = '1;
  localparam logic [1:0] M_NORMAL = 2'd1;
  localparam logic [1:0] M_LIMITED = 2'd2;

  logic [GW-1:0] c_gl, c_gr;
  logic [SW-1:0] c_atk, c_rec;
  logic [TW-1:0] c_ai, c_ri;
  logic          c_both;
  logic [1:0]    c_mode;
  logic [CW-1:0] c_lim;

  logic [OW-1:0] off;
  logic [TW-1:0] atk_tmr, rec_tmr;
  logic          rec_hit;
  logic [CW-1:0] cnt;

  logic [SW-1:0] mag_l, mag_r;
  logic          aov, rov, hit;
  logic [OW-1:0] off_inc;

  assign mag_l = s_left[SW-1]  ? SW'(0) - s_left  : s_left;
  assign mag_r = s_right[SW-1] ? SW'(0) - s_right : s_right;
  assign aov = c_both ? (mag_l > c_atk && mag_r > c_atk) : (mag_l > c_atk || mag_r > c_atk);
  assign rov = c_both ? (mag_l > c_rec && mag_r > c_rec) : (mag_l > c_rec || mag_r > c_rec);
  assign hit = rec_hit | rov;
  assign off_inc = (off == OFF_MAX) ? off : off + OW'(1);

  assign gain_l = (32'(c_gl) > 32'(off)) ? GW'(32'(c_gl) - 32'(off)) : '0;
  assign gain_r = (32'(c_gr) > 32'(off)) ? GW'(32'(c_gr) - 32'(off)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_gl <= '0; c_gr <= '0; c_atk <= '0; c_rec <= '0;
      c_ai <= '0; c_ri <= '0; c_both <= 1'b0; c_mode <= '0; c_lim <= '0;
      off <= '0; atk_tmr <= '0; rec_tmr <= '0; rec_hit <= 1'b0; cnt <= '0;
      attacking <= 1'b0; frozen <= 1'b0;
    end else if (!en || restart) begin
      if (!en) begin
        c_gl <= init_gain_l; c_gr <= init_gain_r; c_atk <= atk_thr; c_rec <= rec_thr;
        c_ai <= atk_ivl; c_ri <= rec_ivl; c_both <= both_mode; c_mode <= rec_mode;
        c_lim <= cnt_limit;
      end
      off <= '0; atk_tmr <= '0; rec_tmr <= '0; rec_hit <= 1'b0; cnt <= '0;
      attacking <= 1'b0; frozen <= 1'b0;
    end else if (s_valid) begin
      if (attacking) begin
        if (atk_tmr != c_ai) begin
          atk_tmr <= atk_tmr + TW'(1);
        end else if (aov) begin
          off <= off_inc;
          atk_tmr <= '0;
        end else begin
          attacking <= 1'b0;
          rec_tmr <= '0;
          rec_hit <= 1'b0;
        end
      end else if (aov) begin
        off <= off_inc;
        attacking <= 1'b1;
        atk_tmr <= '0;
        cnt <= '0;
        frozen <= 1'b0;
      end else if (rec_tmr != c_ri) begin
        rec_tmr <= rec_tmr + TW'(1);
        rec_hit <= hit;
      end else begin
        rec_tmr <= '0;
        rec_hit <= 1'b0;
        case (c_mode)
          M_NORMAL: if (!hit && off != '0) off <= off - OW'(1);
          M_LIMITED:
            if (!frozen) begin
              if (hit) begin
                cnt <= cnt + CW'(1);
                if ({1'b0, cnt} + (CW+1)'(1) >= {1'b0, c_lim}) frozen <= 1'b1;
              end else if (off != '0) begin
                off <= off - OW'(1);
              end
            end
          default: ;
        endcase
      end
    end
  end

  assert_one_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart) |=> ({1'b0, off} == {1'b0, $past(off)} ||
                          {1'b0, off} == {1'b0, $past(off)} + (OW+1)'(1) ||
                          {1'b0, off} + (OW+1)'(1) == {1'b0, $past(off)}));

  assert_attack_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && attacking) |=> (off >= $past(off)));

  assert_equal_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l != '0 && gain_r != '0) |-> (c_gl - gain_l == c_gr - gain_r));

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(c_gl) && $stable(c_gr) && $stable(c_mode) && $stable(c_atk) && $stable(c_both)));

  assert_no_recover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && (c_mode == 2'd0 || c_mode == 2'd3)) |=> (off >= $past(off)));

  assert_frozen_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (c_mode == M_LIMITED && !attacking));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || restart) |=> (off == '0 && !attacking && !frozen));
endmodule

// File: tb/stereo_gain_limiter_tb.sv
module stereo_gain_limiter_tb;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, restart = 1'b0, s_valid = 1'b0;
  logic [15:0] s_left = '0, s_right = '0, atk_thr, rec_thr;
  logic [6:0] init_gain_l, init_gain_r, gain_l, gain_r;
  logic [7:0] atk_ivl, rec_ivl;
  logic both_mode, attacking, frozen;
  logic [1:0] rec_mode;
  logic [3:0] cnt_limit;
  int total = 0, bad = 0, gl = 40, gr = 30;

  always #2 clk = ~clk;

  stereo_gain_limiter u_dut (.clk, .rst_n, .en, .restart, .s_valid, .s_left, .s_right,
    .init_gain_l, .init_gain_r, .atk_thr, .rec_thr, .atk_ivl, .rec_ivl, .both_mode,
    .rec_mode, .cnt_limit, .gain_l, .gain_r, .attacking, .frozen);

  task automatic chk(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic chkg(input int off, input string tag);
    chk(int'(gain_l), (gl > off) ? gl - off : 0, {tag, " gain_l"});
    chk(int'(gain_r), (gr > off) ? gr - off : 0, {tag, " gain_r"});
  endtask

  task automatic smp(input int l, input int r);
    @(negedge clk); s_left = 16'(l); s_right = 16'(r); s_valid = 1'b1;
    @(negedge clk); s_valid = 1'b0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) smp(0, 0);
  endtask

  task automatic loud(input int n);
    for (int i = 0; i < n; i++) smp((i % 2) ? -2000 : 2000, 2000);
  endtask

  task automatic pulse_restart;
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic reen;
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    atk_thr = 16'd1000; rec_thr = 16'd500; atk_ivl = 8'd2; rec_ivl = 8'd3;
    both_mode = 1'b0; rec_mode = 2'd0; cnt_limit = 4'd2;
    init_gain_l = 7'(gl); init_gain_r = 7'(gr);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chkg(0, "R11 reset");
    chk(int'(attacking), 0, "R11 reset attacking");
    chk(int'(frozen), 0, "R11 reset frozen");
    reen;

    smp(1000, -1000);
    chk(int'(attacking), 0, "R1 equal threshold");
    chkg(0, "R1 equal threshold");
    smp(-1001, 0);
    chk(int'(attacking), 1, "R1 one above");
    chkg(1, "R1 one above");
    pulse_restart;
    chkg(0, "R11 restart");
    chk(int'(attacking), 0, "R11 restart attacking");

    for (int n = 1; n <= 12; n++) begin
      loud(n);
      chkg((n + 2) / 3, "R2 burst sweep");
      chk(int'(attacking), 1, "R2 burst attacking");
      pulse_restart;
    end

    loud(1); quiet(2);
    chk(int'(attacking), 1, "R2 skipped samples");
    quiet(1);
    chk(int'(attacking), 0, "R2 attack exit");
    chkg(1, "R2 offset kept");
    quiet(20);
    chkg(1, "R6 no recovery");
    pulse_restart;
    chkg(0, "R6 restart restores");

    smp(0, 3000);
    chkg(1, "R4 either right only");
    pulse_restart;
    both_mode = 1'b1; init_gain_l = 7'd10;
    smp(3000, 0);
    chkg(1, "R5 change while enabled ignored");
    pulse_restart;

    init_gain_l = 7'd50; gl = 50;
    reen;
    chkg(0, "R5 new initial gain");
    smp(3000, 0);
    chkg(0, "R4 both left only");
    smp(0, -3000);
    chk(int'(attacking), 0, "R4 both right only");
    smp(3000, -3000);
    chkg(1, "R4 both channels");

    both_mode = 1'b0; rec_mode = 2'd1;
    reen;
    loud(4); chkg(2, "R7 attack to 2");
    quiet(3); chk(int'(attacking), 0, "R7 exit");
    quiet(3); chkg(2, "R7 before interval end");
    quiet(1); chkg(1, "R7 first recovery");
    quiet(4); chkg(0, "R7 second recovery");
    quiet(4); chkg(0, "R7 floor at zero");

    pulse_restart;
    loud(4); quiet(3);
    smp(700, 0); quiet(3);
    chkg(2, "R8 hold on excursion");
    quiet(4); chkg(1, "R8 resume");
    smp(500, -500); smp(500, 0); smp(0, 500); smp(500, 500);
    chkg(0, "R8 at threshold recovers");

    rec_mode = 2'd2; cnt_limit = 4'd2;
    reen;
    loud(4); quiet(3);
    smp(700, 0); quiet(3);
    chkg(2, "R9 counted interval");
    chk(int'(frozen), 0, "R9 not yet frozen");
    quiet(4); chkg(1, "R9 recovers");
    quiet(3); smp(0, -700);
    chk(int'(frozen), 1, "R9 frozen at limit");
    quiet(4); chkg(1, "R9 no recovery when frozen");
    smp(2000, 0);
    chk(int'(frozen), 0, "R9 attack clears frozen");
    chkg(2, "R9 attack step");
    quiet(3); quiet(4);
    chkg(1, "R9 recovers after new attack");

    rec_mode = 2'd3;
    reen;
    loud(1); quiet(3); quiet(8);
    chkg(1, "R6 mode 3 no recovery");

    rec_mode = 2'd0; atk_ivl = 8'd0;
    init_gain_l = 7'd127; init_gain_r = 7'd100; gl = 127; gr = 100;
    reen;
    for (int i = 0; i < 100; i++) smp(-32768, -32768);
    chkg(100, "R10 offset 100");
    for (int i = 0; i < 100; i++) smp(-32768, 0);
    chkg(127, "R10 saturate");
    chk(int'(gain_l), 0, "R10 left at floor");

    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chkg(0, "R11 disable clears");
    chk(int'(attacking), 0, "R11 disable attacking");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule